// File: doc/BRIEF.md
# Target Request Watchdog and Reset Gate

This block guards a single peripheral target on an on-chip bus. An initiator hands it one request at a time. The block forwards the request to the target and waits for the target's answer. If no answer comes within a limit chosen by software, it ends the request itself with an error response and records the event in a sticky status bit. The limit is picked from a small coded set of multiples of a base period. The base period is a module parameter, given in clock cycles.

Software can also hold the target interface in reset through a control bit. While that bit is set, the reset output to the target is high. Any request in flight is flushed with an error response, and new requests are refused with an error without reaching the target.

A 32-bit register port gives access to the control register, the status register and three read-only identification words. The status register also shows the live level of a sideband error input from the target.

Top module: `tgt_guard`

## Requirements
- R1: After reset, the control word (offset 0x20) and the status word (offset 0x28) read 0, `tgt_rst` is 0 and no response is pending.
- R2: Control bits 10:8 select the time-out limit L = BASE_CYCLES x {1, 4, 16, 64} for codes {1, 2, 3, 4}. For a target that never answers, `ini_rsp_valid` rises with `ini_rsp_err`=1 exactly L clock edges after the edge that accepted the request. Codes 0, 5, 6 and 7 disable the time-out, and the request then stays pending for good.
- R3: The time-out count starts afresh for every accepted request. A target answer that arrives in the last cycle before the limit completes the request without error. A target answer that arrives after a time-out is ignored.
- R4: A time-out ends the request toward the initiator with a one-cycle response carrying `ini_rsp_err`=1. The block then returns to idle and accepts the next request.
- R5: Status bit 8 is set by a time-out and stays set until software writes 1 to that bit. Writing 0 leaves it unchanged.
- R6: Control bit 0 drives `tgt_rst` for as long as it is 1. Status bit 0 shows the same value.
- R7: Setting control bit 0 while a request is pending flushes that request with an error response, does not set status bit 8, and clears the time-out count.
- R8: While control bit 0 is 1, an accepted request gets an error response in the cycle after the accepting edge, and `tgt_req_valid` stays low.
- R9: Status bit 24 shows the live level of `tgt_serr`. Writes do not change it.
- R10: Offset 0x04 reads {IDENT_CODE, IDENT_REV}, offset 0x18 reads {CORE_CODE, CORE_REV}, and offset 0x1C reads {16'h0, VENDOR_CODE}. Each field is 16 bits, with the code in bits 31:16.
- R11: Offsets 0x00 and 0x2C, unmapped offsets, and every reserved bit read as 0. Writes to the read-only words have no effect.
- R12: An accepted request is presented on `tgt_req_valid` until the target raises `tgt_req_ready`. The target's `tgt_rsp_valid` then completes the request with `ini_rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data (combinational on cfg_addr) |
| ini_req_valid | input | 1 | Initiator request |
| ini_req_ready | output | 1 | Block is idle and accepts a request |
| ini_rsp_valid | output | 1 | One-cycle completion toward the initiator |
| ini_rsp_err | output | 1 | Completion is an error (time-out, flush or refusal) |
| tgt_req_valid | output | 1 | Request toward the target |
| tgt_req_ready | input | 1 | Target accepts the request |
| tgt_rsp_valid | input | 1 | Target answer |
| tgt_rst | output | 1 | Reset held on the target interface |
| tgt_serr | input | 1 | Sideband error level from the target |

## Verification
The bench aims at the boundaries of the time-out window. A target answer landing in the final cycle before the limit must win. An off-by-one counter would instead report a false time-out, or report every time-out one cycle late, and the exact latency checks on all four codes would catch either. A late answer that arrives after the time-out must produce no second response. If the design accepted it, the scoreboard would see an unexpected completion. The bench also checks that writing 0 to the sticky bit does not clear it, and that a flush caused by the reset bit does not set it. Finally, it checks that refused requests never reach the target, which would show up as a change in the target model's handshake count.

// File: rtl/tgt_guard_pkg.sv
package tgt_guard_pkg;

    // register byte offsets
    localparam int unsigned OFS_ZERO_LO = 32'h00;
    localparam int unsigned OFS_IDENT   = 32'h04;
    localparam int unsigned OFS_CORE    = 32'h18;
    localparam int unsigned OFS_VENDOR  = 32'h1C;
    localparam int unsigned OFS_CTRL    = 32'h20;
    localparam int unsigned OFS_STAT    = 32'h28;
    localparam int unsigned OFS_ZERO_HI = 32'h2C;

    // field positions
    localparam int unsigned CTRL_RST_BIT  = 0;
    localparam int unsigned CTRL_TMO_LSB  = 8;
    localparam int unsigned TMO_CODE_W    = 3;
    localparam int unsigned STAT_RST_BIT  = 0;
    localparam int unsigned STAT_TMO_BIT  = 8;
    localparam int unsigned STAT_SERR_BIT = 24;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_BUSY = 1'b1
    } xfer_state_e;

    // limit in cycles for a code; 0 means no limit
    function automatic int unsigned tmo_cycles(input logic [TMO_CODE_W-1:0] code,
                                               input int unsigned base);
        int unsigned mult;
        unique case (code)
            3'd1:    mult = 1;
            3'd2:    mult = 4;
            3'd3:    mult = 16;
            3'd4:    mult = 64;
            default: mult = 0;
        endcase
        return mult * base;
    endfunction

endpackage

// File: rtl/tgt_guard_regs.sv
module tgt_guard_regs
    import tgt_guard_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned REG_W       = 32,
    parameter logic [15:0] IDENT_CODE  = 16'h0000,
    parameter logic [15:0] IDENT_REV   = 16'h0000,
    parameter logic [15:0] CORE_CODE   = 16'h0000,
    parameter logic [15:0] CORE_REV    = 16'h0000,
    parameter logic [15:0] VENDOR_CODE = 16'h0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we_i,
    input  logic [ADDR_W-1:0]     cfg_addr_i,
    input  logic [REG_W-1:0]      cfg_wdata_i,
    output logic [REG_W-1:0]      cfg_rdata_o,
    input  logic                  serr_i,
    input  logic                  tmo_evt_i,
    output logic [TMO_CODE_W-1:0] tmo_code_o,
    output logic                  tgt_rst_o
);

    localparam int unsigned HALF_W = REG_W / 2;

    typedef struct packed {
        logic [TMO_CODE_W-1:0] tmo_code;
        logic                  rst_bit;
        logic                  sticky;
    } regs_t;

    regs_t r_d, r_q;

    logic hit_ctrl, hit_stat, clr_req;

    always_comb begin
        hit_ctrl = (cfg_addr_i == ADDR_W'(OFS_CTRL));
        hit_stat = (cfg_addr_i == ADDR_W'(OFS_STAT));
        clr_req  = cfg_we_i && hit_stat && cfg_wdata_i[STAT_TMO_BIT];
    end

    always_comb begin
        r_d = r_q;
        if (cfg_we_i && hit_ctrl) begin
            r_d.tmo_code = cfg_wdata_i[CTRL_TMO_LSB +: TMO_CODE_W];
            r_d.rst_bit  = cfg_wdata_i[CTRL_RST_BIT];
        end
        if (clr_req) begin
            r_d.sticky = 1'b0;
        end
        if (tmo_evt_i) begin
            r_d.sticky = 1'b1;    // a new event wins over a same-cycle clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cfg_rdata_o = '0;
        unique case (int'(cfg_addr_i))
            OFS_IDENT:  cfg_rdata_o = {IDENT_CODE, IDENT_REV};
            OFS_CORE:   cfg_rdata_o = {CORE_CODE, CORE_REV};
            OFS_VENDOR: cfg_rdata_o = {{HALF_W{1'b0}}, VENDOR_CODE};
            OFS_CTRL: begin
                cfg_rdata_o[CTRL_TMO_LSB +: TMO_CODE_W] = r_q.tmo_code;
                cfg_rdata_o[CTRL_RST_BIT]               = r_q.rst_bit;
            end
            OFS_STAT: begin
                cfg_rdata_o[STAT_SERR_BIT] = serr_i;
                cfg_rdata_o[STAT_TMO_BIT]  = r_q.sticky;
                cfg_rdata_o[STAT_RST_BIT]  = r_q.rst_bit;
            end
            default: cfg_rdata_o = '0;
        endcase
    end

    assign tmo_code_o = r_q.tmo_code;
    assign tgt_rst_o  = r_q.rst_bit;

    p_sticky_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt_i |=> r_q.sticky);

    p_sticky_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !tmo_evt_i) |=> !r_q.sticky);

    p_sticky_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sticky && !clr_req) |=> r_q.sticky);

    p_rst_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && hit_ctrl) |=> (tgt_rst_o == $past(cfg_wdata_i[CTRL_RST_BIT])));

endmodule

// File: rtl/tgt_guard_xfer.sv
module tgt_guard_xfer
    import tgt_guard_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TMO_CODE_W-1:0] tmo_code_i,
    input  logic                  hold_rst_i,
    input  logic                  ini_req_valid_i,
    output logic                  ini_req_ready_o,
    output logic                  ini_rsp_valid_o,
    output logic                  ini_rsp_err_o,
    output logic                  tgt_req_valid_o,
    input  logic                  tgt_req_ready_i,
    input  logic                  tgt_rsp_valid_i,
    output logic                  tmo_evt_o
);

    localparam int unsigned MAX_LIMIT = 64 * BASE_CYCLES;
    localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

    typedef struct packed {
        xfer_state_e      state;
        logic             issued;
        logic [CNT_W-1:0] cnt;
        logic             rsp_valid;
        logic             rsp_err;
        logic             tmo_evt;
    } xfer_t;

    xfer_t s_d, s_q;
    logic [CNT_W-1:0] limit;
    logic             limit_on;
    logic             expired;

    always_comb begin
        limit    = CNT_W'(tmo_cycles(tmo_code_i, BASE_CYCLES));
        limit_on = (limit != '0);
        expired  = limit_on && (s_q.cnt >= limit - CNT_W'(1));
    end

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.rsp_err   = 1'b0;
        s_d.tmo_evt   = 1'b0;
        unique case (s_q.state)
            XS_IDLE: begin
                s_d.cnt    = '0;
                s_d.issued = 1'b0;
                if (ini_req_valid_i) begin
                    if (hold_rst_i) begin
                        s_d.rsp_valid = 1'b1;          // refused
                        s_d.rsp_err   = 1'b1;
                    end else begin
                        s_d.state = XS_BUSY;
                    end
                end
            end
            XS_BUSY: begin
                if (hold_rst_i) begin                 // flush
                    s_d.state     = XS_IDLE;
                    s_d.cnt       = '0;
                    s_d.issued    = 1'b0;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_err   = 1'b1;
                end else if (s_q.issued && tgt_rsp_valid_i) begin
                    s_d.state     = XS_IDLE;
                    s_d.cnt       = '0;
                    s_d.issued    = 1'b0;
                    s_d.rsp_valid = 1'b1;
                end else if (expired) begin
                    s_d.state     = XS_IDLE;
                    s_d.cnt       = '0;
                    s_d.issued    = 1'b0;
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_err   = 1'b1;
                    s_d.tmo_evt   = 1'b1;
                end else begin
                    if (s_q.cnt != {CNT_W{1'b1}}) begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                    if (!s_q.issued && tgt_req_ready_i) begin
                        s_d.issued = 1'b1;
                    end
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ini_req_ready_o = (s_q.state == XS_IDLE);
    assign ini_rsp_valid_o = s_q.rsp_valid;
    assign ini_rsp_err_o   = s_q.rsp_err;
    assign tgt_req_valid_o = (s_q.state == XS_BUSY) && !s_q.issued && !hold_rst_i;
    assign tmo_evt_o       = s_q.tmo_evt;

    p_no_fwd_in_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst_i |-> !tgt_req_valid_o);

    p_cnt_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst_i |=> (s_q.cnt == '0));

    p_tmo_is_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt_o |-> (ini_rsp_valid_o && ini_rsp_err_o && ini_req_ready_o));

    p_rsp_ok_needs_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ini_rsp_valid_o && !ini_rsp_err_o) |-> $past(tgt_rsp_valid_i));

endmodule

// File: rtl/tgt_guard.sv
module tgt_guard
    import tgt_guard_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned REG_W       = 32,
    parameter int unsigned BASE_CYCLES = 4,
    parameter logic [15:0] IDENT_CODE  = 16'h0000,
    parameter logic [15:0] IDENT_REV   = 16'h0000,
    parameter logic [15:0] CORE_CODE   = 16'h0000,
    parameter logic [15:0] CORE_REV    = 16'h0000,
    parameter logic [15:0] VENDOR_CODE = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              ini_req_valid,
    output logic              ini_req_ready,
    output logic              ini_rsp_valid,
    output logic              ini_rsp_err,
    output logic              tgt_req_valid,
    input  logic              tgt_req_ready,
    input  logic              tgt_rsp_valid,
    output logic              tgt_rst,
    input  logic              tgt_serr
);

    logic [TMO_CODE_W-1:0] tmo_code;
    logic                  tmo_evt;
    logic                  hold_rst;

    tgt_guard_regs #(
        .ADDR_W      (ADDR_W),
        .REG_W       (REG_W),
        .IDENT_CODE  (IDENT_CODE),
        .IDENT_REV   (IDENT_REV),
        .CORE_CODE   (CORE_CODE),
        .CORE_REV    (CORE_REV),
        .VENDOR_CODE (VENDOR_CODE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .serr_i      (tgt_serr),
        .tmo_evt_i   (tmo_evt),
        .tmo_code_o  (tmo_code),
        .tgt_rst_o   (hold_rst)
    );

    tgt_guard_xfer #(
        .BASE_CYCLES (BASE_CYCLES)
    ) u_xfer (
        .clk             (clk),
        .rst_n           (rst_n),
        .tmo_code_i      (tmo_code),
        .hold_rst_i      (hold_rst),
        .ini_req_valid_i (ini_req_valid),
        .ini_req_ready_o (ini_req_ready),
        .ini_rsp_valid_o (ini_rsp_valid),
        .ini_rsp_err_o   (ini_rsp_err),
        .tgt_req_valid_o (tgt_req_valid),
        .tgt_req_ready_i (tgt_req_ready),
        .tgt_rsp_valid_i (tgt_rsp_valid),
        .tmo_evt_o       (tmo_evt)
    );

    assign tgt_rst = hold_rst;

endmodule

// File: tb/tgt_guard_bench.sv
module tgt_guard_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          BASE       = 4;
    localparam int          AW         = 6;
    localparam logic [15:0] ID_C = 16'hA51C, ID_R = 16'h0102;
    localparam logic [15:0] CO_C = 16'h3C7E, CO_R = 16'h0009;
    localparam logic [15:0] VN_C = 16'h5EED;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          ini_req_valid = 1'b0;
    logic          ini_req_ready, ini_rsp_valid, ini_rsp_err;
    logic          tgt_req_valid;
    logic          tgt_req_ready = 1'b1;
    logic          tgt_rsp_valid = 1'b0;
    logic          tgt_rst;
    logic          tgt_serr = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic  err;
        int    lat;     // -1: any latency
        int    acc;
        string tag;
    } exp_t;
    exp_t expq[$];

    // target model
    bit tgt_hang = 1'b0;
    int tgt_dly  = 0;
    bit pend     = 1'b0;
    int dcnt     = 0;
    int fwd_cnt  = 0;

    tgt_guard #(
        .ADDR_W(AW), .REG_W(32), .BASE_CYCLES(BASE),
        .IDENT_CODE(ID_C), .IDENT_REV(ID_R), .CORE_CODE(CO_C),
        .CORE_REV(CO_R), .VENDOR_CODE(VN_C)
    ) u_tgt_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ini_req_valid(ini_req_valid), .ini_req_ready(ini_req_ready),
        .ini_rsp_valid(ini_rsp_valid), .ini_rsp_err(ini_rsp_err),
        .tgt_req_valid(tgt_req_valid), .tgt_req_ready(tgt_req_ready),
        .tgt_rsp_valid(tgt_rsp_valid), .tgt_rst(tgt_rst), .tgt_serr(tgt_serr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // target model: handshake seen at negedge, answer after tgt_dly cycles
    always @(negedge clk) begin
        tgt_rsp_valid = 1'b0;
        if (pend) begin
            if (dcnt == 0) begin
                tgt_rsp_valid = 1'b1;
                pend = 1'b0;
            end else begin
                dcnt--;
            end
        end
        if (tgt_req_valid && tgt_req_ready) begin
            fwd_cnt++;
            if (!tgt_hang) begin
                pend = 1'b1;
                dcnt = tgt_dly;
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && ini_rsp_valid) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3/R4: unexpected response, err actual %0b expected none", ini_rsp_err);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " rsp_err"}, 32'(ini_rsp_err), 32'(e.err));
                if (e.lat >= 0) check({e.tag, " latency"}, 32'(cyc - e.acc), 32'(e.lat));
            end
        end
    end

    task automatic cfg_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        cfg_addr = AW'(addr);
        #1 data = cfg_rdata;
    endtask

    task automatic send_req(input logic err, input int lat, input string tag);
        exp_t e;
        @(negedge clk);
        check({tag, " ready"}, 32'(ini_req_ready), 32'd1);
        e.err = err; e.lat = lat; e.acc = cyc + 1; e.tag = tag;
        expq.push_back(e);
        ini_req_valid = 1'b1;
        @(negedge clk);
        ini_req_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        while (expq.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_read('h20, rd); check("R1 ctrl", rd, 32'h0);
        cfg_read('h28, rd); check("R1 status", rd, 32'h0);
        check("R1 tgt_rst", 32'(tgt_rst), 32'd0);
        check("R1 rsp", 32'(ini_rsp_valid), 32'd0);

        // R10 identification
        cfg_read('h04, rd); check("R10 ident", rd, {ID_C, ID_R});
        cfg_read('h18, rd); check("R10 core", rd, {CO_C, CO_R});
        cfg_read('h1C, rd); check("R10 vendor", rd, {16'h0, VN_C});

        // R11 zero words, writes ignored
        cfg_write('h04, 32'hFFFF_FFFF);
        cfg_write('h00, 32'hFFFF_FFFF);
        cfg_write('h2C, 32'hFFFF_FFFF);
        cfg_read('h04, rd); check("R11 ident kept", rd, {ID_C, ID_R});
        cfg_read('h00, rd); check("R11 zero lo", rd, 32'h0);
        cfg_read('h2C, rd); check("R11 zero hi", rd, 32'h0);
        cfg_read('h10, rd); check("R11 unmapped", rd, 32'h0);
        cfg_write('h20, 32'hFFFF_F8FE);
        cfg_read('h20, rd); check("R11 ctrl reserved", rd, 32'h0);
        cfg_write('h20, 32'hFFFF_FFFF);
        cfg_read('h20, rd); check("R11 ctrl fields", rd, 32'h0000_0701);
        cfg_write('h20, 32'h0);

        // R12 normal transfer, target slow to accept
        tgt_req_ready = 1'b0; tgt_dly = 5;
        f0 = fwd_cnt;
        send_req(1'b0, -1, "R12");
        repeat (3) @(negedge clk);
        check("R12 valid held", 32'(tgt_req_valid), 32'd1);
        tgt_req_ready = 1'b1;
        wait_rsp();
        check("R12 forwarded", 32'(fwd_cnt - f0), 32'd1);

        // R2 / R4 code 1 time-out
        tgt_hang = 1'b1;
        cfg_write('h20, 32'h0000_0100);
        send_req(1'b1, BASE, "R2 code1");
        wait_rsp();
        cfg_read('h28, rd); check("R5 sticky set", rd, 32'h0000_0100);
        send_req(1'b1, BASE, "R4 next accepted");
        wait_rsp();

        // R5 write-one-to-clear
        cfg_write('h28, 32'h0);
        cfg_read('h28, rd); check("R5 write0 kept", rd, 32'h0000_0100);
        cfg_write('h28, 32'h0000_0100);
        cfg_read('h28, rd); check("R5 write1 cleared", rd, 32'h0);

        // R3 answer on the last cycle wins; per-request restart
        tgt_hang = 1'b0; tgt_dly = 2;
        for (int k = 0; k < 3; k++) begin
            send_req(1'b0, -1, "R3 last-cycle answer");
            wait_rsp();
        end
        cfg_read('h28, rd); check("R3 no sticky", rd, 32'h0);
        tgt_dly = 3;
        send_req(1'b1, BASE, "R3 late answer");
        wait_rsp();
        repeat (6) @(negedge clk);
        check("R3 late ignored", 32'(expq.size()), 32'd0);
        cfg_write('h28, 32'h0000_0100);

        // R2 longer codes
        tgt_hang = 1'b1;
        for (int c = 2; c <= 4; c++) begin
            cfg_write('h20, 32'(c) << 8);
            send_req(1'b1, BASE * (4 ** (c - 1)), "R2 long code");
            wait_rsp();
        end
        cfg_write('h28, 32'h0000_0100);

        // R2 code 5 no limit, then R7 flush
        cfg_write('h20, 32'h0000_0500);
        send_req(1'b1, -1, "R7 flush");
        repeat (300) @(negedge clk);
        check("R2 code5 pending", 32'(expq.size()), 32'd1);
        cfg_write('h20, 32'h0000_0501);
        wait_rsp();
        cfg_read('h28, rd); check("R7 no sticky", rd, 32'h0000_0001);
        check("R6 tgt_rst on", 32'(tgt_rst), 32'd1);

        // R8 refusal during reset
        f0 = fwd_cnt;
        send_req(1'b1, 0, "R8 refused");
        wait_rsp();
        repeat (3) @(negedge clk);
        check("R8 not forwarded", 32'(fwd_cnt - f0), 32'd0);
        check("R8 valid low", 32'(tgt_req_valid), 32'd0);

        // R6 release
        cfg_write('h20, 32'h0);
        cfg_read('h28, rd); check("R6 status off", rd, 32'h0);
        check("R6 tgt_rst off", 32'(tgt_rst), 32'd0);

        // R9 live sideband
        tgt_serr = 1'b1;
        cfg_read('h28, rd); check("R9 serr high", rd, 32'h0100_0000);
        cfg_write('h28, 32'hFFFF_FFFF);
        cfg_read('h28, rd); check("R9 serr write", rd, 32'h0100_0000);
        tgt_serr = 1'b0;
        cfg_read('h28, rd); check("R9 serr low", rd, 32'h0);

        repeat (5) @(negedge clk);
        check("R4 queue empty", 32'(expq.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule